// File: doc/BRIEF.md
# Pointer-Addressed Shared RAM Port

This block gives a host a window onto an on-card byte RAM through four register addresses rather than a memory-mapped aperture. The host loads a read pointer or a write pointer and then moves data through one data register. Each data access is either a single byte or a 16-bit word. After every transfer the pointer that was used steps forward by the number of bytes moved. A driver can therefore stream a whole buffer, starting at an odd or an even offset, without reloading a pointer. A typical transfer is one byte to reach even alignment, then words, then a trailing byte.

The read pointer and the write pointer are separate registers, and the data register is shared between them. A write stream and a read stream can be interleaved without either one disturbing the other.

The RAM is held in two byte-wide banks, one for even addresses and one for odd addresses. A word that starts at an odd address, including one that straddles the top of the RAM, is therefore completed in a single cycle.

An access sequencer registers the kind of access the host made last. It has four states:

- ST_IDLE: no accepted access.
- ST_WROTE: a data write was accepted.
- ST_LOADED: a pointer load was accepted.
- ST_READ_RESP: a data read was accepted and its result is presented.

On every clock edge the sequencer moves to the state of the access decoded in that cycle, from any state:

- A data write goes to ST_WROTE.
- A write to either pointer register goes to ST_LOADED.
- A data read without a write strobe goes to ST_READ_RESP.
- Anything else goes to ST_IDLE.

Top module: `shared_ram_port`

## Requirements
- R1: After reset, host_rvalid is 0, host_rdata is 0, and both the read pointer and the write pointer are 0. Data accesses made without first loading a pointer start at address 0.
- R2: The register select host_sel decodes as follows: 0 is the data register, 1 is the read pointer, and 2 is the write pointer. A write to address 1 or 2 loads that pointer from host_wdata, and only the low log2(RAM_BYTES) bits are kept. A read strobe to address 1 or 2 has no effect and produces no host_rvalid.
- R3: A byte write (host_word=0) to the data register stores host_wdata[7:0] at the write pointer, then advances the write pointer by 1.
- R4: A word write (host_word=1) to the data register stores host_wdata[7:0] at the write pointer and host_wdata[15:8] at the write pointer plus 1, then advances the write pointer by 2. This holds at odd as well as even addresses.
- R5: A byte read of the data register raises host_rvalid in the cycle after the strobe, with host_rdata = {8'h00, byte at the read pointer}. The read pointer then advances by 1. Whenever host_rvalid is 0, host_rdata is 0.
- R6: A word read is little-endian: host_rdata[7:0] is the byte at the read pointer and host_rdata[15:8] is the byte at the read pointer plus 1. The read pointer then advances by 2, at odd or even addresses.
- R7: Both pointers and every byte address wrap modulo RAM_BYTES. A word at address RAM_BYTES-1 uses that byte as its low byte and byte 0 as its high byte.
- R8: A pointer load takes effect for a data access in the very next cycle, with no wait cycle.
- R9: The pointers are independent. Data writes and write-pointer loads never change the read pointer, and data reads and read-pointer loads never change the write pointer.
- R10: When host_wr and host_rd are both high in one cycle, only the write is performed. The read is ignored: host_rvalid stays 0 and the read pointer does not move.
- R11: A word stream of the sizing pattern (start 1, step 3, modulo 2^16) covering the whole RAM from offset 0 reads back unchanged as a word stream from offset 0.
- R12: Any access with host_sel=3 changes no RAM byte and no pointer, and produces no host_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 data, 1 read pointer, 2 write pointer, 3 unused |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_word | input | 1 | Access width: 1 = 16-bit word, 0 = byte |
| host_wdata | input | 16 | Write data, used for data writes and pointer loads |
| host_rdata | output | 16 | Read result, valid while host_rvalid is 1, otherwise 0 |
| host_rvalid | output | 1 | High for one cycle after each accepted data read |

## Verification
The block is exercised with four kinds of traffic:

- A whole-RAM word stream of the sizing pattern. This separates correct pointer stepping over every address from a stuck or skipping pointer.
- Mixed byte/word runs at odd offsets. These separate correct bank steering and little-endian lane order from swapped lanes.
- Accesses that straddle the top of the RAM. These show whether the wrap into byte 0 is handled.
- Interleaved reads, writes and pointer loads, plus strobe collisions and the unused address. These show whether one pointer is disturbed by the other's traffic or by ignored accesses.

A behavioural byte-array model with integer pointers predicts host_rvalid and host_rdata for every cycle.

// File: rtl/shp_pkg.sv
package shp_pkg;

    // Register select decode; the values are the host-visible addresses.
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_RPTR = 2'd1,
        SEL_WPTR = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Kind of access accepted in a cycle.
    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_DATA_WR = 2'd1,
        OP_PTR_LD  = 2'd2,
        OP_DATA_RD = 2'd3
    } host_op_e;

    // Sequencer state: what was accepted in the previous cycle.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WROTE     = 2'd1,
        ST_LOADED    = 2'd2,
        ST_READ_RESP = 2'd3
    } seq_state_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 16;

endpackage

// File: rtl/shp_host_seq.sv
module shp_host_seq
    import shp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_sel,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_word,
    input  logic       rd_ptr_lsb,
    output logic       data_wr,
    output logic       data_rd,
    output logic       rptr_ld,
    output logic       wptr_ld,
    output logic       resp_valid,
    output logic       resp_word,
    output logic       resp_odd
);

    reg_sel_e   sel;
    host_op_e   op;
    seq_state_e state_q, state_d;

    assign sel = reg_sel_e'(host_sel);

    // Decode: a write strobe always wins over a read strobe.
    always_comb begin
        op = OP_NONE;
        if (host_wr) begin
            unique case (sel)
                SEL_DATA:           op = OP_DATA_WR;
                SEL_RPTR, SEL_WPTR: op = OP_PTR_LD;
                default:            op = OP_NONE;
            endcase
        end else if (host_rd && sel == SEL_DATA) begin
            op = OP_DATA_RD;
        end
    end

    assign data_wr = (op == OP_DATA_WR);
    assign data_rd = (op == OP_DATA_RD);
    assign rptr_ld = (op == OP_PTR_LD) && (sel == SEL_RPTR);
    assign wptr_ld = (op == OP_PTR_LD) && (sel == SEL_WPTR);

    // Next state: every state follows the access decoded this cycle.
    always_comb begin
        unique case (op)
            OP_DATA_WR: state_d = ST_WROTE;
            OP_PTR_LD:  state_d = ST_LOADED;
            OP_DATA_RD: state_d = ST_READ_RESP;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Response attributes captured with each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_word <= 1'b0;
            resp_odd  <= 1'b0;
        end else if (data_rd) begin
            resp_word <= host_word;
            resp_odd  <= rd_ptr_lsb;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_READ_RESP:                 resp_valid = 1'b1;
            ST_IDLE, ST_WROTE, ST_LOADED: resp_valid = 1'b0;
            default:                      resp_valid = 1'b0;
        endcase
    end

    // R5: an accepted data read is answered in the next cycle.
    a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_sel == 2'd0) |=> resp_valid);

    // R10 / R12: no response without an accepted data read.
    a_r10_quiet_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr && host_sel == 2'd0) |=> !resp_valid);

endmodule

// File: rtl/shp_ptr.sv
module shp_ptr #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic              word,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] step;

    assign step = word ? ADDR_W'(2) : ADDR_W'(1);

    // Arithmetic in ADDR_W bits wraps modulo the power-of-two RAM size.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (load) ptr <= load_val;
        else if (adv)  ptr <= ptr + step;
    end

    // R9: an idle pointer keeps its value.
    a_r9_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(ptr));

    // R8: a loaded value is in place for the next access.
    a_r8_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr == $past(load_val)));

endmodule

// File: rtl/shp_bank.sv
module shp_bank #(
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wbyte,
    input  logic             re,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rbyte
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wbyte;
        if (re) rbyte <= cells[ridx];
    end

endmodule

// File: rtl/shared_ram_port.sv
module shared_ram_port
    import shp_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  host_sel,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_word,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_rvalid
);

    localparam int unsigned ADDR_W = $clog2(RAM_BYTES);
    localparam int unsigned IDX_W  = ADDR_W - 1;
    localparam int unsigned NBANK  = 2;
    localparam int unsigned NPTR   = 2;  // index 0 read, 1 write

    logic data_wr, data_rd, rptr_ld, wptr_ld;
    logic resp_word, resp_odd;

    logic [ADDR_W-1:0] ptr_q   [NPTR];
    logic              ptr_ld  [NPTR];
    logic              ptr_adv [NPTR];
    logic [ADDR_W-1:0] rd_ptr, wr_ptr;

    logic [7:0]       lo_byte, hi_byte;
    logic [7:0]       bank_rbyte [NBANK];
    logic             bank_we    [NBANK];
    logic [IDX_W-1:0] bank_widx  [NBANK];
    logic [7:0]       bank_wbyte [NBANK];
    logic [IDX_W-1:0] bank_ridx  [NBANK];

    shp_host_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_word  (host_word),
        .rd_ptr_lsb (rd_ptr[0]),
        .data_wr    (data_wr),
        .data_rd    (data_rd),
        .rptr_ld    (rptr_ld),
        .wptr_ld    (wptr_ld),
        .resp_valid (host_rvalid),
        .resp_word  (resp_word),
        .resp_odd   (resp_odd)
    );

    assign ptr_ld[0]  = rptr_ld;
    assign ptr_ld[1]  = wptr_ld;
    assign ptr_adv[0] = data_rd;
    assign ptr_adv[1] = data_wr;

    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
        shp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ptr_ld[p]),
            .load_val (host_wdata[ADDR_W-1:0]),
            .adv      (ptr_adv[p]),
            .word     (host_word),
            .ptr      (ptr_q[p])
        );
    end

    assign rd_ptr = ptr_q[0];
    assign wr_ptr = ptr_q[1];

    // Even bank holds even byte addresses, odd bank the odd ones. The bank
    // matching the pointer parity carries the low byte. For an odd pointer
    // the even bank supplies the high byte from the following row.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic w_first;
        logic [IDX_W-1:0] w_row, r_row;

        assign w_first = (wr_ptr[0] == (b == 1));
        assign w_row   = wr_ptr[ADDR_W-1:1];
        assign r_row   = rd_ptr[ADDR_W-1:1];

        if (b == 0) begin : g_even
            assign bank_widx[b] = wr_ptr[0] ? w_row + IDX_W'(1) : w_row;
            assign bank_ridx[b] = rd_ptr[0] ? r_row + IDX_W'(1) : r_row;
        end else begin : g_odd
            assign bank_widx[b] = w_row;
            assign bank_ridx[b] = r_row;
        end

        assign bank_we[b]    = data_wr && (w_first || host_word);
        assign bank_wbyte[b] = w_first ? host_wdata[7:0] : host_wdata[15:8];

        shp_bank #(.IDX_W(IDX_W)) u_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .widx  (bank_widx[b]),
            .wbyte (bank_wbyte[b]),
            .re    (data_rd),
            .ridx  (bank_ridx[b]),
            .rbyte (bank_rbyte[b])
        );
    end

    assign lo_byte = resp_odd ? bank_rbyte[1] : bank_rbyte[0];
    assign hi_byte = resp_odd ? bank_rbyte[0] : bank_rbyte[1];

    always_comb begin
        if (!host_rvalid)   host_rdata = '0;
        else if (resp_word) host_rdata = {hi_byte, lo_byte};
        else                host_rdata = {8'h00, lo_byte};
    end

    // R9: write-side traffic leaves the read pointer alone.
    a_r9_rptr_ignores_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel != 2'd1) |=> $stable(rd_ptr));

    // R9: read-side traffic leaves the write pointer alone.
    a_r9_wptr_ignores_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && host_rd) |=> $stable(wr_ptr));

    // R12: the unused address moves neither pointer.
    a_r12_unused_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel == 2'd3) |=> ($stable(rd_ptr) && $stable(wr_ptr)));

endmodule

// File: tb/sim_shared_ram_port.sv
module sim_shared_ram_port;

    localparam int CLK_PERIOD = 10;
    localparam int BYTES      = 1024;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_word = 1'b0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        host_rvalid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state
    logic [7:0] ref_mem [BYTES];
    int         ref_rp = 0;
    int         ref_wp = 0;
    logic       exp_valid = 1'b0;
    logic [15:0] exp_data = 16'h0;
    string      exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_ram_port #(.RAM_BYTES(BYTES)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_word  (host_word),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_rvalid(host_rvalid)
    );

    task automatic compare();
        checks++;
        if (host_rvalid !== exp_valid || host_rdata !== exp_data) begin
            failures++;
            $display("FAIL %s: rvalid=%0b rdata=%04h expected rvalid=%0b rdata=%04h",
                     exp_tag, host_rvalid, host_rdata, exp_valid, exp_data);
        end
    endtask

    // One host cycle: check the previous result, drive, and advance the model.
    task automatic step(input logic [1:0] sel, input logic wr, input logic rd,
                        input logic word, input logic [15:0] d, input string tag);
        @(negedge clk);
        compare();
        host_sel = sel; host_wr = wr; host_rd = rd; host_word = word; host_wdata = d;
        exp_valid = 1'b0;
        exp_data  = 16'h0;
        exp_tag   = tag;
        if (wr) begin
            if (sel == 2'd0) begin
                ref_mem[ref_wp] = d[7:0];
                if (word) ref_mem[(ref_wp + 1) % BYTES] = d[15:8];
                ref_wp = (ref_wp + (word ? 2 : 1)) % BYTES;
            end else if (sel == 2'd1) begin
                ref_rp = int'(d) % BYTES;
            end else if (sel == 2'd2) begin
                ref_wp = int'(d) % BYTES;
            end
        end else if (rd && sel == 2'd0) begin
            exp_valid = 1'b1;
            if (word) exp_data = {ref_mem[(ref_rp + 1) % BYTES], ref_mem[ref_rp]};
            else      exp_data = {8'h00, ref_mem[ref_rp]};
            ref_rp = (ref_rp + (word ? 2 : 1)) % BYTES;
        end
    endtask

    task automatic wbyte(input logic [7:0] v, input string t); step(2'd0, 1, 0, 0, {8'h00, v}, t); endtask
    task automatic wword(input logic [15:0] v, input string t); step(2'd0, 1, 0, 1, v, t); endtask
    task automatic rbyte(input string t); step(2'd0, 0, 1, 0, 16'h0, t); endtask
    task automatic rword(input string t); step(2'd0, 0, 1, 1, 16'h0, t); endtask
    task automatic ldr(input logic [15:0] v, input string t); step(2'd1, 1, 0, 0, v, t); endtask
    task automatic ldw(input logic [15:0] v, input string t); step(2'd2, 1, 0, 0, v, t); endtask
    task automatic idle(input string t); step(2'd0, 0, 0, 0, 16'h0, t); endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stimulus
        logic [15:0] pat;
        for (int i = 0; i < BYTES; i++) ref_mem[i] = 8'h00;

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            compare();
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: pointers start at zero; R4 odd-aligned word write, R6 odd word read
        wbyte(8'h5A, "R1");
        wword(16'h1234, "R4");
        rbyte("R1");
        rword("R6");
        idle("R6");

        // R11: sizing stream over the whole RAM
        ldw(16'h0000, "R11");
        pat = 16'd1;
        for (int i = 0; i < BYTES/2; i++) begin
            wword(pat, "R11");
            pat = pat + 16'd3;
        end
        ldr(16'h0000, "R11");
        for (int i = 0; i < BYTES/2; i++) rword("R11");
        idle("R11");

        // R3 / R5: byte streams
        ldw(16'd3, "R3");
        wbyte(8'h11, "R3");
        wbyte(8'h22, "R3");
        wbyte(8'h33, "R3");
        ldr(16'd3, "R5");
        rbyte("R5");
        rbyte("R5");
        rbyte("R5");
        rbyte("R5");

        // R4 / R6: lead byte, words, trailing byte
        ldw(16'd101, "R4");
        wbyte(8'hAA, "R4");
        wword(16'hBBCC, "R4");
        wword(16'hDDEE, "R4");
        wbyte(8'hFF, "R4");
        ldr(16'd100, "R6");
        for (int i = 0; i < 4; i++) rword("R6");
        ldr(16'd101, "R6");
        rword("R6");
        rbyte("R6");
        rword("R6");

        // R7: wrap at the top of RAM; R2: high pointer bits dropped
        ldw(16'(BYTES - 1), "R7");
        wword(16'hBEEF, "R7");
        wbyte(8'h77, "R7");
        ldr(16'(BYTES - 1), "R7");
        rword("R7");
        rbyte("R7");
        ldr(16'(BYTES - 1), "R7");
        rbyte("R7");
        rbyte("R7");
        ldr(16'h0405, "R2");
        rbyte("R2");
        ldw(16'h0C40, "R2");
        wword(16'h6655, "R2");
        ldr(16'h0040, "R2");
        rword("R2");

        // R8: back-to-back loads and reads
        ldr(16'd10, "R8");
        rword("R8");
        ldr(16'd21, "R8");
        rbyte("R8");
        ldw(16'd30, "R8");
        wbyte(8'h9C, "R8");
        ldr(16'd30, "R8");
        rbyte("R8");

        // R9: interleaved independent streams
        ldw(16'd200, "R9");
        ldr(16'd300, "R9");
        for (int i = 0; i < 4; i++) begin
            wword(16'hA000 + 16'(i), "R9");
            rword("R9");
        end
        rbyte("R9");
        ldw(16'd500, "R9");
        rbyte("R9");
        wbyte(8'h3E, "R9");
        rword("R9");
        ldr(16'd200, "R9");
        for (int i = 0; i < 4; i++) rword("R9");
        ldr(16'd500, "R9");
        rbyte("R9");

        // R10: write and read strobes together
        ldw(16'd600, "R10");
        ldr(16'd600, "R10");
        step(2'd0, 1, 1, 1, 16'h4321, "R10");
        idle("R10");
        rword("R10");
        step(2'd0, 1, 1, 0, 16'h0088, "R10");
        rbyte("R10");

        // R12: unused address; R2: read strobe on pointer addresses
        ldr(16'd610, "R12");
        ldw(16'd610, "R12");
        step(2'd3, 1, 0, 1, 16'hFFFF, "R12");
        step(2'd3, 0, 1, 1, 16'h0000, "R12");
        step(2'd1, 0, 1, 0, 16'h0000, "R2");
        step(2'd2, 0, 1, 0, 16'h0000, "R2");
        rword("R12");
        wbyte(8'h1D, "R12");
        ldr(16'd610, "R12");
        rbyte("R12");
        idle("R12");
        idle("R12");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule